// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the device half of a receive DMA path. Software places a ring of four-word descriptors in memory and marks each one as handed to the device. For every frame that arrives on a byte stream, the block reads the descriptor at its current ring position. If the device owns that descriptor, the block stores the frame into the descriptor's buffer and then writes a completion status word over the first descriptor word. If software still holds the descriptor, the frame is discarded and counted.

After a completed descriptor the block moves 16 bytes forward in the ring. When the descriptor it has just used carries an end-of-ring flag, it returns to the ring base instead. The ring base is taken while reception is stopped. Frames are accepted only while reception runs. A frame that has already started is always finished, even if reception is stopped part way through it.

Memory is reached through a single-cycle synchronous port that never stalls. A read returns its data on the cycle after the request. Descriptor words sit at byte offsets 0 (status), 4 (control and size), 8 (buffer address) and 12 (link, never read).

Top module: `rx_desc_writer`

## Requirements
- R1: While reset is held, and after its release, `mem_req_o` and `rx_ready_o` are low and `miss_cnt_o` is zero.
- R2: While `rx_en_i` is low and no frame is in progress, the block makes no memory request and holds `rx_ready_o` low. The ring position is reloaded from `ring_base_i` during that time.
- R3: Before it takes the first byte of a frame, the block reads the words at ring position +0, +4 and +8, in that order.
- R4: In an owned descriptor, frame bytes are packed little-endian: byte k goes to bits 8*(k mod 4)+7:8*(k mod 4) of the word written at buffer address + 4*floor(k/4). Unused lanes of the final word are written as zero.
- R5: After the last buffer word, the block writes one status word to ring position +0. In that word, bit 31 (ownership) is 0, bits 30:16 hold the frame byte count including the check sequence, bit 8 (last descriptor) is 1, bit 15 is the error flag, and all other bits are 0.
- R6: Buffer capacity is control bits 10:0 rounded down to a multiple of 4. Words that start at or beyond the capacity are not written. A frame with more bytes than the capacity sets status bit 15, and its length field still gives the full count.
- R7: If status bit 31 of the current descriptor is 0, the frame is consumed with no memory write. `miss_cnt_o` then rises by one, and the ring position is unchanged.
- R8: After a status write-back the ring position advances by 16. If control bit 25 of that descriptor is set, the position returns to `ring_base_i` instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ring_base_i | input | AW | Byte address of the first descriptor |
| rx_en_i | input | 1 | Reception enable |
| rx_valid_i | input | 1 | Stream byte valid |
| rx_data_i | input | 8 | Stream byte |
| rx_last_i | input | 1 | Last byte of the frame |
| rx_ready_o | output | 1 | Byte accepted when high together with valid |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write when high, read when low |
| mem_addr_o | output | AW | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read request |
| miss_cnt_o | output | CNT_W | Frames dropped because software held the descriptor |

## Verification
The hardest state to reach is a ring wrap that lands on a descriptor the device has already completed, because its ownership bit is then still clear. The stimulus builds a three-entry ring whose last entry has a tiny buffer and the end-of-ring flag. Three frames fill the ring, and the third is truncated. The fourth frame therefore meets the cleared descriptor at the base and must be dropped and counted. The bench then returns that descriptor to the device and sends a one-byte frame. A later reload of the base while reception is stopped builds a one-entry ring that wraps onto itself.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_STS, ST_RD_CTL, ST_RD_BUF, ST_LATCH, ST_RECV, ST_DROP, ST_WB
  } rxd_state_e;

  localparam int OWN_BIT    = 31;
  localparam int EOR_BIT    = 25;
  localparam int DESC_BYTES = 16;
endpackage

// File: rtl/rxd_pack.sv
module rxd_pack #(
  parameter int LEN_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             acc_i,
  input  logic [7:0]       data_i,
  input  logic             last_i,
  output logic [31:0]      word_o,
  output logic             word_done_o,
  output logic [LEN_W-3:0] word_idx_o,
  output logic [LEN_W-1:0] cnt_o
);
  logic [23:0]      hold_q;
  logic [LEN_W-1:0] cnt_q;
  logic [1:0]       lane;

  assign lane = cnt_q[1:0];

  always_comb begin
    word_o = {8'h00, hold_q};
    word_o[lane*8 +: 8] = data_i;
  end

  assign word_done_o = acc_i && (lane == 2'd3 || last_i);
  assign word_idx_o  = cnt_q[LEN_W-1:2];
  assign cnt_o       = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      hold_q <= '0;
      cnt_q  <= '0;
    end else if (acc_i) begin
      cnt_q  <= cnt_q + 1'b1;
      hold_q <= word_done_o ? 24'h0 : word_o[23:0];
    end
  end
endmodule

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          adv_i,
  input  logic          wrap_i,
  output logic [AW-1:0] ptr_o
);
  import rxd_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= base_i;
    else if (adv_i)  ptr_o <= wrap_i ? base_i : ptr_o + AW'(DESC_BYTES);
  end
endmodule

// File: rtl/rxd_status_fmt.sv
module rxd_status_fmt #(
  parameter int LEN_W = 15
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic             err_i,
  output logic [31:0]      word_o
);
  logic [14:0] len_field;

  assign len_field = 15'(len_i);
  // own=0 | length | error | reserved | last-descriptor | reserved
  assign word_o = {1'b0, len_field, err_i, 6'b0, 1'b1, 8'h00};
endmodule

// File: rtl/rx_desc_writer.sv
module rx_desc_writer #(
  parameter int AW     = 32,
  parameter int SIZE_W = 11,
  parameter int LEN_W  = 15,
  parameter int CNT_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    ring_base_i,
  input  logic             rx_en_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_last_i,
  output logic             rx_ready_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic [31:0]      mem_rdata_i,
  output logic [CNT_W-1:0] miss_cnt_o
);
  import rxd_pkg::*;

  rxd_state_e        state_q, state_d;
  logic              own_q, eor_q, ovf_q;
  logic [SIZE_W-1:0] cap_q;
  logic [AW-1:0]     buf_q, ptr;
  logic [CNT_W-1:0]  miss_q;

  logic              acc;
  logic [31:0]       pk_word, sts_word;
  logic              pk_done;
  logic [LEN_W-3:0]  pk_idx;
  logic [LEN_W-1:0]  pk_cnt, cap_ext, word_off;
  logic              word_fits, byte_fits;

  assign rx_ready_o = (state_q == ST_RECV) || (state_q == ST_DROP);
  assign acc        = rx_valid_i && rx_ready_o;
  assign cap_ext    = LEN_W'(cap_q);
  assign word_off   = {pk_idx, 2'b00};
  assign word_fits  = word_off < cap_ext;
  assign byte_fits  = pk_cnt < cap_ext;
  assign miss_cnt_o = miss_q;

  rxd_pack #(.LEN_W(LEN_W)) i_pack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (state_q == ST_LATCH),
    .acc_i       (acc && state_q == ST_RECV),
    .data_i      (rx_data_i),
    .last_i      (rx_last_i),
    .word_o      (pk_word),
    .word_done_o (pk_done),
    .word_idx_o  (pk_idx),
    .cnt_o       (pk_cnt)
  );

  rxd_ring_ptr #(.AW(AW)) i_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (state_q == ST_IDLE && !rx_en_i),
    .base_i (ring_base_i),
    .adv_i  (state_q == ST_WB),
    .wrap_i (eor_q),
    .ptr_o  (ptr)
  );

  rxd_status_fmt #(.LEN_W(LEN_W)) i_fmt (
    .len_i  (pk_cnt),
    .err_i  (ovf_q),
    .word_o (sts_word)
  );

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = ptr;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_RD_STS: mem_req_o = 1'b1;
      ST_RD_CTL: begin mem_req_o = 1'b1; mem_addr_o = ptr + AW'(4); end
      ST_RD_BUF: begin mem_req_o = 1'b1; mem_addr_o = ptr + AW'(8); end
      ST_RECV: if (pk_done && word_fits) begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = buf_q + AW'(word_off);
        mem_wdata_o = pk_word;
      end
      ST_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = sts_word;
      end
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (rx_en_i && rx_valid_i) state_d = ST_RD_STS;
      ST_RD_STS: state_d = ST_RD_CTL;
      ST_RD_CTL: state_d = ST_RD_BUF;
      ST_RD_BUF: state_d = ST_LATCH;
      ST_LATCH:  state_d = own_q ? ST_RECV : ST_DROP;
      ST_RECV:   if (acc && rx_last_i) state_d = ST_WB;
      ST_DROP:   if (acc && rx_last_i) state_d = ST_IDLE;
      ST_WB:     state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      own_q   <= 1'b0;
      eor_q   <= 1'b0;
      ovf_q   <= 1'b0;
      cap_q   <= '0;
      buf_q   <= '0;
      miss_q  <= '0;
    end else begin
      state_q <= state_d;
      // read data lags the request by one cycle
      if (state_q == ST_RD_CTL) own_q <= mem_rdata_i[OWN_BIT];
      if (state_q == ST_RD_BUF) begin
        cap_q <= {mem_rdata_i[SIZE_W-1:2], 2'b00};
        eor_q <= mem_rdata_i[EOR_BIT];
      end
      if (state_q == ST_LATCH) begin
        buf_q <= mem_rdata_i[AW-1:0];
        ovf_q <= 1'b0;
      end
      if (state_q == ST_RECV && acc && !byte_fits) ovf_q <= 1'b1;
      if (state_q == ST_DROP && acc && rx_last_i) miss_q <= miss_q + 1'b1;
    end
  end
endmodule

// File: rtl/rx_desc_writer_chk.sv
module rx_desc_writer_chk
  import rxd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_en_i,
  input logic [AW-1:0]    ring_base_i,
  input logic             rx_ready_o,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [AW-1:0]    mem_addr_o,
  input logic [31:0]      mem_wdata_o,
  input logic [CNT_W-1:0] miss_cnt_o,
  input rxd_state_e       state_q,
  input logic [AW-1:0]    ptr
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!mem_req_o && !rx_ready_o && miss_cnt_o == '0)
        else $error("reset state violated");
    end
  end

  p_stopped_no_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_i && state_q == ST_IDLE) |=> !rx_ready_o);

  p_fetch_stride_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_STS) |=> (mem_req_o && !mem_we_o && mem_addr_o == $past(mem_addr_o) + AW'(4)));

  p_status_fmt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WB) |-> (mem_we_o && !mem_wdata_o[31] && mem_wdata_o[8] && mem_addr_o == ptr));

  p_drop_silent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DROP) |-> !mem_req_o);

  p_miss_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_cnt_o != $past(miss_cnt_o)) |-> (miss_cnt_o == $past(miss_cnt_o) + 1'b1));

  p_ptr_move_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr != $past(ptr)) |-> (ptr == $past(ptr) + AW'(16) || ptr == ring_base_i));
endmodule

bind rx_desc_writer rx_desc_writer_chk #(.AW(AW), .CNT_W(CNT_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_en_i     (rx_en_i),
  .ring_base_i (ring_base_i),
  .rx_ready_o  (rx_ready_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .miss_cnt_o  (miss_cnt_o),
  .state_q     (state_q),
  .ptr         (ptr)
);

// File: tb/test_rx_desc_writer.sv
module test_rx_desc_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ring_base = '0;
  logic        rx_en = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_last = 1'b0;
  logic        rx_ready, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [15:0] miss_cnt;

  int checks = 0;
  int failures = 0;
  int exp_miss = 0;
  logic [31:0] mbase = 0, mptr = 0;
  logic [31:0] mem [0:255];

  logic [31:0] ea_q[$];
  logic [31:0] ed_q[$];
  string       et_q[$];
  logic [31:0] rd_q[$];

  always #2 clk = ~clk;

  rx_desc_writer i_rx_desc_writer (
    .clk_i(clk), .rst_ni(rst_n), .ring_base_i(ring_base), .rx_en_i(rx_en),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_last_i(rx_last),
    .rx_ready_o(rx_ready), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .miss_cnt_o(miss_cnt)
  );

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Per-clock comparison of every memory write against the model queue
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      if (mem_we) begin
        if (ea_q.size() == 0) begin
          check(1'b0, "R7 unexpected write", mem_addr, 32'hffff_ffff);
        end else begin
          logic [31:0] ea, ed;
          string et;
          ea = ea_q.pop_front();
          ed = ed_q.pop_front();
          et = et_q.pop_front();
          check(mem_addr == ea, {et, " addr"}, mem_addr, ea);
          check(mem_wdata == ed, {et, " data"}, mem_wdata, ed);
        end
      end else begin
        rd_q.push_back(mem_addr);
      end
    end
  end

  task automatic set_desc(input logic [31:0] a, input bit own, input int size, input bit eor, input logic [31:0] b);
    mem[a[9:2]]     = {own, 31'h0};
    mem[a[9:2] + 1] = (32'(eor) << 25) | 32'(size);
    mem[a[9:2] + 2] = b;
    mem[a[9:2] + 3] = '0;
  endtask

  function automatic logic [7:0] fbyte(input int id, input int j);
    return 8'(id * 37 + j);
  endfunction

  task automatic send_frame(input int n, input int id);
    logic [31:0] st, ctl, bufa, dptr;
    int cap;
    bit own;
    dptr = mptr;
    st   = mem[mptr[9:2]];
    ctl  = mem[mptr[9:2] + 1];
    bufa = mem[mptr[9:2] + 2];
    own  = st[31];
    cap  = int'(ctl[10:0]) & ~3;
    if (own) begin
      for (int k = 0; 4 * k < n; k++) begin
        logic [31:0] w;
        w = '0;
        for (int l = 0; l < 4; l++)
          if (4 * k + l < n) w[8*l +: 8] = fbyte(id, 4 * k + l);
        if (4 * k < cap) begin
          ea_q.push_back(bufa + 32'(4 * k));
          ed_q.push_back(w);
          et_q.push_back(4 * k + 4 > cap ? "R6 buffer word" : "R4 buffer word");
        end
      end
      ea_q.push_back(mptr);
      ed_q.push_back({1'b0, 15'(n), (n > cap), 6'b0, 1'b1, 8'h00});
      et_q.push_back(n > cap ? "R6 status" : "R5 status");
      mptr = ctl[25] ? mbase : mptr + 32'd16;
    end else begin
      exp_miss++;
    end
    rd_q.delete();
    for (int j = 0; j < n; j++) begin
      rx_valid = 1'b1;
      rx_data  = fbyte(id, j);
      rx_last  = (j == n - 1);
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
    end
    rx_valid = 1'b0;
    rx_last  = 1'b0;
    repeat (3) @(negedge clk);
    check(rd_q.size() == 3, "R3 read count", 32'(rd_q.size()), 32'd3);
    if (rd_q.size() == 3) begin
      check(rd_q[0] == dptr,      "R3 R8 status read addr", rd_q[0], dptr);
      check(rd_q[1] == dptr + 4,  "R3 control read addr",   rd_q[1], dptr + 4);
      check(rd_q[2] == dptr + 8,  "R3 buffer read addr",    rd_q[2], dptr + 8);
    end
    check(ea_q.size() == 0, "R5 pending writes", 32'(ea_q.size()), 32'd0);
    check(miss_cnt == 16'(exp_miss), "R7 miss count", 32'(miss_cnt), 32'(exp_miss));
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    set_desc(32'h000, 1'b1, 64, 1'b0, 32'h100);
    set_desc(32'h010, 1'b1, 64, 1'b0, 32'h180);
    set_desc(32'h020, 1'b1, 10, 1'b1, 32'h200);
    repeat (3) @(negedge clk);
    check(!mem_req && !rx_ready, "R1 quiet in reset", {30'h0, mem_req, rx_ready}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mem_req && !rx_ready, "R1 quiet after reset", {30'h0, mem_req, rx_ready}, 32'h0);
    check(miss_cnt == 0, "R1 miss reset", 32'(miss_cnt), 32'h0);
    rx_en = 1'b1;
    mbase = 32'h000;
    mptr  = 32'h000;
    @(negedge clk);

    send_frame(13, 1);   // R4 partial final word
    send_frame(8, 2);    // R4 whole words
    send_frame(20, 3);   // R6 truncation, end of ring
    send_frame(7, 4);    // R7 wrap onto completed descriptor -> drop
    check(mem[0][31] == 1'b0 && mem[0][30:16] == 15'd13, "R7 dropped frame left status", mem[0], {1'b0, 15'd13, 1'b0, 6'b0, 1'b1, 8'h00});
    set_desc(32'h000, 1'b1, 64, 1'b0, 32'h100);
    send_frame(1, 5);    // R4 single byte

    // R2: stop, reload base
    rx_en = 1'b0;
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = 8'h5a;
    rx_last  = 1'b1;
    begin
      bit quiet;
      quiet = 1'b1;
      for (int c = 0; c < 5; c++) begin
        @(negedge clk);
        if (rx_ready || mem_req) quiet = 1'b0;
      end
      check(quiet, "R2 stopped ignores stream", {31'h0, quiet}, 32'h1);
    end
    rx_valid = 1'b0;
    rx_last  = 1'b0;
    ring_base = 32'h040;
    set_desc(32'h040, 1'b1, 32, 1'b1, 32'h300);
    @(negedge clk);
    @(negedge clk);
    rx_en = 1'b1;
    mbase = 32'h040;
    mptr  = 32'h040;
    send_frame(9, 6);    // R2 new base
    check(mem[16][31] == 1'b0, "R5 ownership cleared", {31'h0, mem[16][31]}, 32'h0);
    mem[16][31] = 1'b1;
    send_frame(5, 7);    // R8 single-entry ring wraps onto itself

    summary();
    $finish;
  end
endmodule